// File: doc/BRIEF.md
# Memory Row Chip-Select Decoder

This block turns a physical byte address into a chip select for one of several memory rows. Each row is described by a single 8-bit cumulative boundary value. That value, shifted up by 24 bits, is the exclusive top of the row. A row begins where the row below it ends, and row 0 begins at address zero. This means the whole map is set by one ascending list of boundaries, with a granularity of 16 MB. Rows of different sizes, from 16 MB up to 512 MB, can sit side by side.

Software or boot logic loads the boundaries through a small write port. The decoder compares every incoming address against all rows in parallel. It returns a registered one-hot chip select and a hit flag one cycle later. It also reports, combinationally, which rows are unpopulated. A row is unpopulated when its boundary equals the boundary of the row below it. Such a row is never selected.

Top module: `row_cs_decoder`

## Requirements
- R1: After reset every boundary is 0, `cs_onehot` is 0, `hit` is 0 and `row_empty` is all ones.
- R2: When `cfg_we` is high at a clock edge, `cfg_limit` is stored as the boundary of the row given by `cfg_idx`. All other rows keep their values.
- R3: Row i (base = boundary of row i-1, or 0 for row 0) is selected when base*2^24 <= addr < boundary_i*2^24. Bit i of `cs_onehot` stands for row i.
- R4: `cs_onehot` and `hit` show the decode of the address sampled at the previous rising clock edge. They hold their value between edges.
- R5: Bit i of `row_empty` is 1 exactly when boundary_i equals the base of row i. A row with this bit set is never selected.
- R6: An address that falls in no row's window gives `cs_onehot` = 0 and `hit` = 0. This includes any address at or above the top boundary.
- R7: `cs_onehot` has at most one bit set, and `hit` is 1 exactly when a bit is set.
- R8: When windows overlap because the boundaries were programmed out of order, the lowest-numbered matching row is selected.
- R9: Mixed row sizes decode exactly at their edges. For example, 16 MB and 512 MB rows side by side switch rows at the first byte of each boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Boundary write strobe |
| cfg_idx | input | 2 | Row whose boundary is written |
| cfg_limit | input | 8 | Boundary value (address bits 31:24 of the row's exclusive top) |
| addr | input | 32 | Physical byte address to decode |
| cs_onehot | output | 4 | Registered one-hot row select |
| hit | output | 1 | Registered flag: address fell inside a populated row |
| row_empty | output | 4 | Per-row unpopulated flag, from the stored boundaries |

## Verification
A boundary write takes effect at its clock edge, and `row_empty` follows combinationally in the same cycle. The bench therefore reads `row_empty` one nanosecond after that edge. The chip select and hit flag take one register stage. The bench drives an address on a falling edge and samples the outputs one nanosecond after the next rising edge. One scenario changes the address in mid-cycle and confirms that the outputs still hold the previous decode until the following edge.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  localparam int ADDR_BITS  = 32;
  localparam int LIMIT_BITS = 8;
  localparam int SHIFT      = ADDR_BITS - LIMIT_BITS;

  typedef logic [ADDR_BITS-1:0]  addr_t;
  typedef logic [LIMIT_BITS-1:0] limit_t;

  // Expand a boundary value into a full byte address.
  function automatic addr_t to_bound(limit_t v);
    return {v, {SHIFT{1'b0}}};
  endfunction

  // Half-open window test: lo <= a < hi.
  function automatic logic in_window(addr_t lo, addr_t hi, addr_t a);
    return (a >= lo) && (a < hi);
  endfunction
endpackage

// File: rtl/rowdec_limit_file.sv
module rowdec_limit_file
  import rowdec_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  limit_t                           wdata,
  output logic [ROWS-1:0][LIMIT_BITS-1:0]  lims
);
  for (genvar g = 0; g < ROWS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lims[g] <= '0;
      else if (we && (int'(idx) == g))
        lims[g] <= wdata;
    end
  end
endmodule

// File: rtl/rowdec_window_cmp.sv
module rowdec_window_cmp
  import rowdec_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic [ROWS-1:0][LIMIT_BITS-1:0] lims,
  input  addr_t                           addr,
  output logic [ROWS-1:0]                 match,
  output logic [ROWS-1:0]                 empty
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    limit_t base_v;
    if (g == 0) begin : g_first
      assign base_v = '0;
    end else begin : g_next
      assign base_v = lims[g-1];
    end
    assign empty[g] = (lims[g] == base_v);
    assign match[g] = in_window(to_bound(base_v), to_bound(lims[g]), addr);
  end
endmodule

// File: rtl/rowdec_pick.sv
module rowdec_pick #(
  parameter int ROWS = 4
) (
  input  logic [ROWS-1:0] match,
  output logic [ROWS-1:0] onehot
);
  always_comb begin
    logic taken;
    taken  = 1'b0;
    onehot = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (match[i] && !taken) begin
        onehot[i] = 1'b1;
        taken     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/row_cs_decoder.sv
module row_cs_decoder
  import rowdec_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [LIMIT_BITS-1:0] cfg_limit,
  input  logic [ADDR_BITS-1:0]  addr,
  output logic [ROWS-1:0]       cs_onehot,
  output logic                  hit,
  output logic [ROWS-1:0]       row_empty
);
  logic [ROWS-1:0][LIMIT_BITS-1:0] lims;
  logic [ROWS-1:0]                 match_vec;
  logic [ROWS-1:0]                 pick_vec;
  logic                            any_match;

  rowdec_limit_file #(.ROWS(ROWS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_limit), .lims(lims)
  );

  rowdec_window_cmp #(.ROWS(ROWS)) u_cmp (
    .lims(lims), .addr(addr), .match(match_vec), .empty(row_empty)
  );

  rowdec_pick #(.ROWS(ROWS)) u_pick (
    .match(match_vec), .onehot(pick_vec)
  );

  assign any_match = |match_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_onehot <= '0;
      hit       <= 1'b0;
    end else begin
      cs_onehot <= pick_vec;
      hit       <= any_match;
    end
  end
endmodule

// File: rtl/row_cs_decoder_chk.sv
module row_cs_decoder_chk #(
  parameter int ROWS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ROWS-1:0] cs,
  input logic            hit,
  input logic [ROWS-1:0] row_empty,
  input logic [ROWS-1:0] match_vec,
  input logic            any_match
);
  localparam logic [ROWS-1:0] ONE = {{(ROWS-1){1'b0}}, 1'b1};

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs)); // R7
  AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (cs != '0)); // R7
  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |=> hit); // R4
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_match |=> (!hit && cs == '0)); // R6
  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != '0) |-> ((cs & $past(match_vec)) == cs)); // R3
  AST_EMPTY_NEVER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != '0) |-> ((cs & $past(row_empty)) == '0)); // R5
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != '0) |-> (((cs - ONE) & $past(match_vec)) == '0)); // R8
endmodule

bind row_cs_decoder row_cs_decoder_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs_onehot), .hit(hit),
  .row_empty(row_empty), .match_vec(match_vec), .any_match(any_match)
);

// File: tb/tb_row_cs_decoder.sv
module tb_row_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_limit = '0;
  logic [31:0] addr = '0;
  logic [3:0]  cs_onehot;
  logic        hit;
  logic [3:0]  row_empty;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int bnd [4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  row_cs_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_limit(cfg_limit), .addr(addr), .cs_onehot(cs_onehot),
    .hit(hit), .row_empty(row_empty)
  );

  function automatic logic [3:0] model_cs(logic [31:0] a);
    int unit;
    int lo;
    unit = int'(a >> 24);
    for (int r = 0; r < 4; r++) begin
      lo = (r == 0) ? 0 : bnd[r-1];
      if (unit >= lo && unit < bnd[r]) return 4'(1 << r);
    end
    return 4'b0000;
  endfunction

  function automatic logic [3:0] model_empty();
    logic [3:0] e;
    for (int r = 0; r < 4; r++)
      e[r] = (bnd[r] == ((r == 0) ? 0 : bnd[r-1]));
    return e;
  endfunction

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_limit(int r, int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(r); cfg_limit = 8'(v);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    bnd[r] = v;
  endtask

  task automatic load(int a0, int a1, int a2, int a3, string req);
    put_limit(0, a0); put_limit(1, a1); put_limit(2, a2); put_limit(3, a3);
    expect_eq(req, 32'(row_empty), 32'(model_empty()));
  endtask

  task automatic probe(logic [31:0] a, logic [3:0] exp_cs, string req);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    expect_eq(req, 32'(cs_onehot), 32'(exp_cs));
    expect_eq(req, 32'(model_cs(a)), 32'(exp_cs));
    expect_eq(req, 32'(hit), 32'(exp_cs != 4'b0));
  endtask

  task automatic t_reset();
    #1;
    expect_eq("R1", 32'(cs_onehot), 32'h0);
    expect_eq("R1", 32'(hit), 32'h0);
    expect_eq("R1", 32'(row_empty), 32'hF);
    probe(32'h0000_0000, 4'b0000, "R1");
  endtask

  task automatic t_basic();
    load(2, 4, 8, 16, "R2");
    expect_eq("R2", 32'(row_empty), 32'h0);
    probe(32'h0000_0000, 4'b0001, "R3");
    probe(32'h01FF_FFFF, 4'b0001, "R3");
    probe(32'h0200_0000, 4'b0010, "R3");
    probe(32'h07FF_FFFF, 4'b0100, "R3");
    probe(32'h0800_0000, 4'b1000, "R3");
    probe(32'h0FFF_FFFF, 4'b1000, "R3");
    probe(32'h1000_0000, 4'b0000, "R6");
    probe(32'hFFFF_FFFF, 4'b0000, "R6");
    put_limit(2, 9);
    probe(32'h0800_0000, 4'b0100, "R2");
    probe(32'h0200_0000, 4'b0010, "R2");
  endtask

  task automatic t_empty();
    load(2, 2, 6, 6, "R5");
    expect_eq("R5", 32'(row_empty), 32'b1010);
    probe(32'h0200_0000, 4'b0100, "R5");
    probe(32'h0600_0000, 4'b0000, "R5");
    load(0, 4, 4, 4, "R5");
    expect_eq("R5", 32'(row_empty), 32'b1101);
    probe(32'h0000_0000, 4'b0010, "R5");
    probe(32'h0400_0000, 4'b0000, "R5");
  endtask

  task automatic t_sizes();
    load(1, 33, 34, 66, "R9");
    probe(32'h00FF_FFFF, 4'b0001, "R9");
    probe(32'h0100_0000, 4'b0010, "R9");
    probe(32'h20FF_FFFF, 4'b0010, "R9");
    probe(32'h2100_0000, 4'b0100, "R9");
    probe(32'h2200_0000, 4'b1000, "R9");
    probe(32'h41FF_FFFF, 4'b1000, "R9");
    probe(32'h4200_0000, 4'b0000, "R9");
    load(16, 32, 64, 255, "R9");
    probe(32'hFEFF_FFFF, 4'b1000, "R9");
    probe(32'hFF00_0000, 4'b0000, "R6");
  endtask

  task automatic t_overlap();
    load(8, 4, 12, 12, "R8");
    expect_eq("R8", 32'(row_empty), 32'b1000);
    probe(32'h0500_0000, 4'b0001, "R8");
    probe(32'h0900_0000, 4'b0100, "R8");
    probe(32'h0C00_0000, 4'b0000, "R8");
  endtask

  task automatic t_latency();
    load(2, 4, 8, 16, "R4");
    probe(32'h0300_0000, 4'b0010, "R4");
    addr = 32'h0900_0000;
    #1;
    expect_eq("R4", 32'(cs_onehot), 32'b0010);
    @(posedge clk); #1;
    expect_eq("R4", 32'(cs_onehot), 32'b1000);
    expect_eq("R7", 32'(hit), 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_basic();
    t_empty();
    t_sizes();
    t_overlap();
    t_latency();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule